// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a digital monitor or TV link, all clocked by one pixel clock. Two position counters drive it. A line counter runs from 0 to the line period minus one, and position 0 is the first clock of the hsync pulse. A frame-wide counter counts every pixel clock of the frame, and position 0 is the first clock of the vsync pulse. Because of this, the frame period, the vsync length and the vertical active window are all given in pixel clocks, not in lines. For a frame of `L` lines of `H` clocks each, the frame period is `L*H` and a vsync of `n` lines is `n*H`.

Pixels come in over a valid/ready handshake and go out as 24-bit RGB. Outside the active window the output carries a border colour. An active-window clock with no valid pixel carries a fill colour instead. With recovery enabled, the output then stays on fill colour until the frame ends, and the stream starts again at the next frame.

A write-only register port loads the configuration. Geometry and polarity are copied into shadow registers only at a frame boundary. The enable bit likewise takes effect only at a frame boundary. A one-clock `vsync_irq` strobe marks the first clock of each vsync, so software can wait on it to see that an enable change has taken hold.

Control states and transitions:
- `ST_IDLE` is the disabled state.
- `ST_RUN` is the normal scan state.
- `ST_FILL` is the starved state, which outputs the fill colour until the frame ends.
- *start*: `ST_IDLE` to `ST_RUN`, on the clock after enable is seen set.
- *wrap*: `ST_RUN` to `ST_RUN`, at frame end with enable still set.
- *starve*: `ST_RUN` to `ST_FILL`, on an active clock with no valid pixel while recovery is on.
- *resync*: `ST_FILL` to `ST_RUN`, at frame end with enable set.
- *stop*: `ST_RUN` or `ST_FILL` to `ST_IDLE`, at frame end with enable clear.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the block is idle. `hsync`, `vsync`, `de`, `pix_ready` and `vsync_irq` are 0, and `rgb` is 0 because the border colour resets to 0.
- R2: While running, hsync is active for line positions 0 to pulse-1. The line counter wraps after period-1, and it also restarts at frame end. Register 1 holds the period in bits [11:0] and the pulse width in bits [23:12].
- R3: While running, vsync is active for frame positions 0 to vlen-1. The frame counter wraps after fper-1. Register 2 holds fper and register 3 holds vlen, both in pixel clocks.
- R4: `de` is 1 only when running, the line position is in [hbeg, hend] and the frame position is in [vbeg+skew, vend+skew], with both ends inclusive. Register 4 holds hbeg in [11:0] and hend in [23:12]. Registers 5, 6 and 7 hold vbeg, vend and skew.
- R5: Control register 0 bit 1 makes hsync active-low and bit 2 makes vsync active-low. With the bit clear the signal is active-high. When idle, each sync sits at its inactive level.
- R6: When `de` is 0, `rgb` equals the border colour from register 8. The colour is packed as R[23:16], G[15:8], B[7:0].
- R7: On an active clock with `pix_valid` low, `rgb` equals the fill colour from register 9, which resets to 0xFFFFFF. With recovery set (control bit 3), every later active clock of that frame also outputs fill with `pix_ready` low, and normal output returns at the next frame.
- R8: Writing the enable (control bit 0) changes nothing until a frame boundary. A running block finishes its current frame before it stops.
- R9: `vsync_irq` pulses for exactly one clock, on the first clock of every vsync while running.
- R10: While disabled, the counters are held at 0. `de`, `pix_ready` and `vsync_irq` are 0 and both syncs are inactive.
- R11: Geometry and polarity written during a running frame take effect only from the next frame start.
- R12: On an active clock with `pix_valid` high and no starvation, `pix_ready` is 1 and `rgb` equals `pix_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 24 | Register write data |
| pix_valid | input | 1 | Source has a pixel |
| pix_data | input | 24 | Source pixel, R[23:16] G[15:8] B[7:0] |
| pix_ready | output | 1 | Pixel consumed this clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| rgb | output | 24 | Output pixel |
| vsync_irq | output | 1 | One-clock vsync start strobe |

## Verification
Two functions can land on the same clock:
- starvation on the last clock of a frame, when the active window runs to frame end and the frame counter wraps;
- a register write on a frame boundary, when the shadow copy and the enable commit both happen.

The bench sets up a geometry whose active window ends on the final clock of the frame. It then forces `pix_valid` low on exactly that clock, so the frame wrap must win: the next frame starts in `ST_RUN` and is not starved. Random register writes fall at arbitrary frame positions, including boundaries, and a cycle model in the bench judges every output on every clock.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FILL = 2'd2
    } st_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    localparam int RGB_W = 24;

    // register indices
    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_LINE   = 4'd1;
    localparam logic [3:0] A_FPER   = 4'd2;
    localparam logic [3:0] A_VLEN   = 4'd3;
    localparam logic [3:0] A_HWIN   = 4'd4;
    localparam logic [3:0] A_VBEG   = 4'd5;
    localparam logic [3:0] A_VEND   = 4'd6;
    localparam logic [3:0] A_SKEW   = 4'd7;
    localparam logic [3:0] A_BORDER = 4'd8;
    localparam logic [3:0] A_FILL   = 4'd9;

    // control bits
    localparam int CB_EN    = 0;
    localparam int CB_HNEG  = 1;
    localparam int CB_VNEG  = 2;
    localparam int CB_RECOV = 3;

endpackage

// File: rtl/dtg_cfg.sv
module dtg_cfg
    import dtg_pkg::*;
#(
    parameter int HCW = 12,
    parameter int FCW = 24,
    parameter int AW  = 4,
    parameter int DW  = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic           commit,
    output logic           en_req,
    output logic           recov,
    output rgb_t           border,
    output rgb_t           fill,
    output logic [HCW-1:0] sh_htot,
    output logic [HCW-1:0] sh_hpw,
    output logic [HCW-1:0] sh_hbeg,
    output logic [HCW-1:0] sh_hend,
    output logic [FCW-1:0] sh_fper,
    output logic [FCW-1:0] sh_vlen,
    output logic [FCW-1:0] sh_vbeg,
    output logic [FCW-1:0] sh_vend,
    output logic           sh_hneg,
    output logic           sh_vneg
);

    localparam int HI = HCW;

    logic [3:0]     p_ctrl;
    logic [HCW-1:0] p_htot, p_hpw, p_hbeg, p_hend;
    logic [FCW-1:0] p_fper, p_vlen, p_vbeg, p_vend, p_skew;

    // programmed copy, written from the port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_ctrl <= '0;
            p_htot <= '0;
            p_hpw  <= '0;
            p_hbeg <= '0;
            p_hend <= '0;
            p_fper <= '0;
            p_vlen <= '0;
            p_vbeg <= '0;
            p_vend <= '0;
            p_skew <= '0;
            border <= '0;
            fill   <= '1;
        end else if (we) begin
            case (addr)
                A_CTRL:   p_ctrl <= wdata[3:0];
                A_LINE: begin
                    p_htot <= wdata[HCW-1:0];
                    p_hpw  <= wdata[HI +: HCW];
                end
                A_FPER:   p_fper <= wdata[FCW-1:0];
                A_VLEN:   p_vlen <= wdata[FCW-1:0];
                A_HWIN: begin
                    p_hbeg <= wdata[HCW-1:0];
                    p_hend <= wdata[HI +: HCW];
                end
                A_VBEG:   p_vbeg <= wdata[FCW-1:0];
                A_VEND:   p_vend <= wdata[FCW-1:0];
                A_SKEW:   p_skew <= wdata[FCW-1:0];
                A_BORDER: border <= rgb_t'(wdata[RGB_W-1:0]);
                A_FILL:   fill   <= rgb_t'(wdata[RGB_W-1:0]);
                default:  ;
            endcase
        end
    end

    // shadow copy, loaded only at a frame boundary; skew folded in here
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_htot <= '0;
            sh_hpw  <= '0;
            sh_hbeg <= '0;
            sh_hend <= '0;
            sh_fper <= '0;
            sh_vlen <= '0;
            sh_vbeg <= '0;
            sh_vend <= '0;
            sh_hneg <= 1'b0;
            sh_vneg <= 1'b0;
        end else if (commit) begin
            sh_htot <= p_htot;
            sh_hpw  <= p_hpw;
            sh_hbeg <= p_hbeg;
            sh_hend <= p_hend;
            sh_fper <= p_fper;
            sh_vlen <= p_vlen;
            sh_vbeg <= p_vbeg + p_skew;
            sh_vend <= p_vend + p_skew;
            sh_hneg <= p_ctrl[CB_HNEG];
            sh_vneg <= p_ctrl[CB_VNEG];
        end
    end

    assign en_req = p_ctrl[CB_EN];
    assign recov  = p_ctrl[CB_RECOV];

endmodule

// File: rtl/dtg_count.sv
module dtg_count #(
    parameter int HCW = 12,
    parameter int FCW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           running,
    input  logic [HCW-1:0] htot,
    input  logic [FCW-1:0] fper,
    output logic [HCW-1:0] hcnt,
    output logic [FCW-1:0] fcnt,
    output logic           frame_end
);

    logic line_end;

    assign line_end  = (hcnt == htot - 1'b1);
    assign frame_end = running && (fcnt == fper - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            fcnt <= '0;
        end else if (!running || frame_end) begin
            hcnt <= '0;
            fcnt <= '0;
        end else begin
            hcnt <= line_end ? '0 : hcnt + 1'b1;
            fcnt <= fcnt + 1'b1;
        end
    end

endmodule

// File: rtl/dtg_fsm.sv
module dtg_fsm
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic recov,
    input  logic frame_end,
    input  logic starve,
    output st_e  state,
    output logic running,
    output logic filling,
    output logic commit
);

    st_e nstate;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (en_req) nstate = ST_RUN;
            ST_RUN: begin
                if (frame_end)            nstate = en_req ? ST_RUN : ST_IDLE;
                else if (starve && recov) nstate = ST_FILL;
            end
            ST_FILL: if (frame_end)      nstate = en_req ? ST_RUN : ST_IDLE;
            default:                     nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        running = (state != ST_IDLE);
        filling = (state == ST_FILL);
        commit  = (state == ST_IDLE) || frame_end;
    end

endmodule

// File: rtl/dtg_pix.sv
module dtg_pix
    import dtg_pkg::*;
#(
    parameter int HCW = 12,
    parameter int FCW = 24
) (
    input  logic           running,
    input  logic           filling,
    input  logic [HCW-1:0] hcnt,
    input  logic [FCW-1:0] fcnt,
    input  logic [HCW-1:0] hpw,
    input  logic [HCW-1:0] hbeg,
    input  logic [HCW-1:0] hend,
    input  logic [FCW-1:0] vlen,
    input  logic [FCW-1:0] vbeg,
    input  logic [FCW-1:0] vend,
    input  logic           hneg,
    input  logic           vneg,
    input  rgb_t           border,
    input  rgb_t           fill,
    input  logic           pix_valid,
    input  rgb_t           pix_data,
    output logic           hsync,
    output logic           vsync,
    output logic           de,
    output logic           pix_ready,
    output logic           starve,
    output logic           vsync_irq,
    output rgb_t           rgb
);

    logic hs_on, vs_on, h_in, v_in;

    always_comb begin
        hs_on     = running && (hcnt < hpw);
        vs_on     = running && (fcnt < vlen);
        h_in      = (hcnt >= hbeg) && (hcnt <= hend);
        v_in      = (fcnt >= vbeg) && (fcnt <= vend);
        de        = running && h_in && v_in;
        pix_ready = de && !filling;
        starve    = de && !pix_valid;
        vsync_irq = running && (fcnt == '0);
        hsync     = hs_on ^ hneg;
        vsync     = vs_on ^ vneg;
        if (!de)                       rgb = border;
        else if (filling || !pix_valid) rgb = fill;
        else                           rgb = pix_data;
    end

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter  int HCW = 12,
    parameter  int FCW = 24,
    localparam int AW  = 4,
    localparam int DW  = (2*HCW > FCW) ? ((2*HCW > RGB_W) ? 2*HCW : RGB_W)
                                       : ((FCW > RGB_W) ? FCW : RGB_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             pix_valid,
    input  logic [RGB_W-1:0] pix_data,
    output logic             pix_ready,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [RGB_W-1:0] rgb,
    output logic             vsync_irq
);

    st_e            state;
    logic           running, filling, commit, frame_end, starve;
    logic           en_req, recov, sh_hneg, sh_vneg;
    rgb_t           border_c, fill_c, rgb_c;
    logic [HCW-1:0] sh_htot, sh_hpw, sh_hbeg, sh_hend, hcnt;
    logic [FCW-1:0] sh_fper, sh_vlen, sh_vbeg, sh_vend, fcnt;

    dtg_cfg #(.HCW(HCW), .FCW(FCW), .AW(AW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .commit(commit), .en_req(en_req), .recov(recov),
        .border(border_c), .fill(fill_c),
        .sh_htot(sh_htot), .sh_hpw(sh_hpw), .sh_hbeg(sh_hbeg),
        .sh_hend(sh_hend), .sh_fper(sh_fper), .sh_vlen(sh_vlen),
        .sh_vbeg(sh_vbeg), .sh_vend(sh_vend),
        .sh_hneg(sh_hneg), .sh_vneg(sh_vneg)
    );

    dtg_count #(.HCW(HCW), .FCW(FCW)) u_count (
        .clk(clk), .rst_n(rst_n), .running(running),
        .htot(sh_htot), .fper(sh_fper),
        .hcnt(hcnt), .fcnt(fcnt), .frame_end(frame_end)
    );

    dtg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .recov(recov),
        .frame_end(frame_end), .starve(starve), .state(state),
        .running(running), .filling(filling), .commit(commit)
    );

    dtg_pix #(.HCW(HCW), .FCW(FCW)) u_pix (
        .running(running), .filling(filling), .hcnt(hcnt), .fcnt(fcnt),
        .hpw(sh_hpw), .hbeg(sh_hbeg), .hend(sh_hend),
        .vlen(sh_vlen), .vbeg(sh_vbeg), .vend(sh_vend),
        .hneg(sh_hneg), .vneg(sh_vneg),
        .border(border_c), .fill(fill_c),
        .pix_valid(pix_valid), .pix_data(rgb_t'(pix_data)),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_ready(pix_ready),
        .starve(starve), .vsync_irq(vsync_irq), .rgb(rgb_c)
    );

    assign rgb = rgb_c;

endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk
    import dtg_pkg::*;
#(
    parameter int HCW = 12,
    parameter int FCW = 24
) (
    input logic             clk,
    input logic             rst_n,
    input st_e              state,
    input logic             frame_end,
    input logic             commit,
    input logic [HCW-1:0]   sh_htot,
    input logic [FCW-1:0]   sh_fper,
    input logic             de,
    input logic             pix_ready,
    input logic             vsync_irq,
    input logic [RGB_W-1:0] rgb,
    input rgb_t             border_c
);

    // R9: strobe lasts one clock
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |=> !vsync_irq);

    // R10: disabled block is quiet
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!de && !pix_ready && !vsync_irq));

    // R12: a pixel is only taken inside the window
    a_r12_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> de);

    // R7: once starved, fill holds to the end of the frame
    a_r7_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && !frame_end) |=> (state == ST_FILL));

    // R8: a running block never stops mid-frame
    a_r8_no_midframe_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !frame_end) |=> (state != ST_IDLE));

    // R11: geometry shadow changes only at a commit point
    a_r11_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(sh_htot) && $stable(sh_fper)));

    // R6: border outside the window
    a_r6_border_out: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (rgb == border_c));

endmodule

bind disp_timing_gen disp_timing_gen_chk #(.HCW(HCW), .FCW(FCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .frame_end(frame_end),
    .commit(commit), .sh_htot(sh_htot), .sh_fper(sh_fper), .de(de),
    .pix_ready(pix_ready), .vsync_irq(vsync_irq), .rgb(rgb),
    .border_c(border_c)
);

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
module tb_disp_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [23:0] pix_data = '0;
    logic        pix_ready, hsync, vsync, de, vsync_irq;
    logic [23:0] rgb;

    always #4 clk = ~clk;  // 125 MHz

    disp_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .hsync(hsync), .vsync(vsync), .de(de),
        .rgb(rgb), .vsync_irq(vsync_irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the programmed and shadow state
    logic        m_en, m_hneg, m_vneg, m_recov;
    logic [11:0] p_htot, p_hpw, p_hbeg, p_hend, s_htot, s_hpw, s_hbeg, s_hend, m_h;
    logic [23:0] p_fper, p_vlen, p_vbeg, p_vend, p_skew;
    logic [23:0] s_fper, s_vlen, s_vbeg, s_vend, m_f, m_border, m_fill;
    logic        s_hneg, s_vneg;
    int          m_st;     // 0 idle, 1 run, 2 fill
    int          drop_mod; // 0: always valid, else drop 1 in drop_mod
    bit          drop_last;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string ctx();
        if (m_st == 0) return " [R10 idle]";
        if (!m_en) return " [R8 stop pending]";
        if (p_htot != s_htot || p_fper != s_fper || p_hbeg != s_hbeg)
            return " [R11 shadow pending]";
        return "";
    endfunction

    task automatic model_reset();
        m_en = 0; m_hneg = 0; m_vneg = 0; m_recov = 0;
        p_htot = 0; p_hpw = 0; p_hbeg = 0; p_hend = 0;
        p_fper = 0; p_vlen = 0; p_vbeg = 0; p_vend = 0; p_skew = 0;
        s_htot = 0; s_hpw = 0; s_hbeg = 0; s_hend = 0;
        s_fper = 0; s_vlen = 0; s_vbeg = 0; s_vend = 0;
        s_hneg = 0; s_vneg = 0;
        m_border = 0; m_fill = 24'hFFFFFF;
        m_st = 0; m_h = 0; m_f = 0;
    endtask

    // one clock: drive pixel inputs, check outputs, advance model
    task automatic tick();
        bit run, e_hs, e_vs, e_de, e_rdy, e_irq, fe, bnd, starve;
        logic [23:0] e_rgb;
        int nst;
        if (drop_mod == 0) pix_valid = 1'b1;
        else pix_valid = (($urandom % drop_mod) != 0);
        if (drop_last && m_st != 0 && m_f == s_fper - 24'd1) pix_valid = 1'b0;
        pix_data = 24'($urandom);
        #1;
        run   = (m_st != 0);
        e_hs  = (run && m_h < s_hpw) ^ s_hneg;
        e_vs  = (run && m_f < s_vlen) ^ s_vneg;
        e_de  = run && m_h >= s_hbeg && m_h <= s_hend && m_f >= s_vbeg && m_f <= s_vend;
        e_rdy = e_de && m_st != 2;
        e_irq = run && m_f == 0;
        if (!e_de) e_rgb = m_border;
        else if (m_st == 2 || !pix_valid) e_rgb = m_fill;
        else e_rgb = pix_data;
        chk({"R2/R5 hsync", ctx()}, 32'(hsync), 32'(e_hs));
        chk({"R3/R5 vsync", ctx()}, 32'(vsync), 32'(e_vs));
        chk({"R4 de", ctx()}, 32'(de), 32'(e_de));
        chk({"R12 pix_ready", ctx()}, 32'(pix_ready), 32'(e_rdy));
        chk({"R9 vsync_irq", ctx()}, 32'(vsync_irq), 32'(e_irq));
        if (!e_de) chk({"R6 border", ctx()}, 32'(rgb), 32'(e_rgb));
        else if (m_st == 2 || !pix_valid) chk({"R7 fill", ctx()}, 32'(rgb), 32'(e_rgb));
        else chk({"R12 pixel", ctx()}, 32'(rgb), 32'(e_rgb));
        // advance
        fe     = run && (m_f == s_fper - 24'd1);
        bnd    = (m_st == 0) || fe;
        starve = e_de && !pix_valid;
        case (m_st)
            0: nst = m_en ? 1 : 0;
            1: nst = fe ? (m_en ? 1 : 0) : ((starve && m_recov) ? 2 : 1);
            default: nst = fe ? (m_en ? 1 : 0) : 2;
        endcase
        if (!run || fe) begin m_h = 0; m_f = 0; end
        else begin
            m_h = (m_h == s_htot - 12'd1) ? 12'd0 : m_h + 12'd1;
            m_f = m_f + 24'd1;
        end
        if (bnd) begin
            s_htot = p_htot; s_hpw = p_hpw; s_hbeg = p_hbeg; s_hend = p_hend;
            s_fper = p_fper; s_vlen = p_vlen;
            s_vbeg = p_vbeg + p_skew; s_vend = p_vend + p_skew;
            s_hneg = m_hneg; s_vneg = m_vneg;
        end
        m_st = nst;
        if (cfg_we) begin
            case (cfg_addr)
                4'd0: begin m_en = cfg_wdata[0]; m_hneg = cfg_wdata[1];
                            m_vneg = cfg_wdata[2]; m_recov = cfg_wdata[3]; end
                4'd1: begin p_htot = cfg_wdata[11:0]; p_hpw = cfg_wdata[23:12]; end
                4'd2: p_fper = cfg_wdata;
                4'd3: p_vlen = cfg_wdata;
                4'd4: begin p_hbeg = cfg_wdata[11:0]; p_hend = cfg_wdata[23:12]; end
                4'd5: p_vbeg = cfg_wdata;
                4'd6: p_vend = cfg_wdata;
                4'd7: p_skew = cfg_wdata;
                4'd8: m_border = cfg_wdata;
                4'd9: m_fill = cfg_wdata;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [23:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_geom(input int ht, input int pw, input int hb, input int he,
                            input int lines, input int vl_lines, input int vb,
                            input int ve, input int sk);
        wr(4'd1, 24'((pw << 12) | ht));
        wr(4'd4, 24'((he << 12) | hb));
        wr(4'd2, 24'(lines * ht));
        wr(4'd3, 24'(vl_lines * ht));
        wr(4'd5, 24'(vb));
        wr(4'd6, 24'(ve));
        wr(4'd7, 24'(sk));
    endtask

    task automatic rand_geom();
        int ht, pw, hb, he, ln, vl, fp, sk, vb, ve;
        ln = 3 + int'($urandom % 4);
        ht = 6 + int'($urandom % 11);
        pw = 1 + int'($urandom % (ht - 2));
        hb = int'($urandom % (ht - 1));
        he = hb + int'($urandom % (ht - hb));
        vl = 1 + int'($urandom % (ln - 1));
        fp = ln * ht;
        sk = int'($urandom % 3);
        vb = int'($urandom % (fp - 4));
        ve = vb + int'($urandom % (fp - sk - vb));
        set_geom(ht, pw, hb, he, ln, vl, vb, ve, sk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        drop_mod = 0; drop_last = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk("R1 hsync", 32'(hsync), 0);
        chk("R1 vsync", 32'(vsync), 0);
        chk("R1 de", 32'(de), 0);
        chk("R1 pix_ready", 32'(pix_ready), 0);
        chk("R1 vsync_irq", 32'(vsync_irq), 0);
        chk("R1 rgb border reset", 32'(rgb), 0);
        @(negedge clk);

        // directed geometry: active window runs to the last frame clock
        set_geom(10, 2, 4, 9, 6, 2, 30, 59, 0);
        wr(4'd8, 24'h102030);
        // R5: idle level follows polarity
        wr(4'd0, 24'h6);
        run_n(2);
        #1;
        chk("R5 idle hsync inactive-high", 32'(hsync), 1);
        chk("R5 idle vsync inactive-high", 32'(vsync), 1);
        chk("R10 idle de", 32'(de), 0);
        @(negedge clk);

        // start, full valid stream
        wr(4'd0, 24'h9);
        run_n(180);
        // random drops with recovery
        drop_mod = 20;
        run_n(300);
        // starve on the wrap clock
        drop_mod = 0; drop_last = 1;
        run_n(130);
        drop_last = 0;
        // recovery off
        drop_mod = 7;
        wr(4'd0, 24'h1);
        run_n(200);
        // mid-frame geometry change (R11) then mid-frame disable (R8)
        drop_mod = 0;
        run_n(17);
        set_geom(12, 3, 2, 10, 4, 1, 12, 40, 2);
        run_n(30);
        wr(4'd0, 24'h0);
        run_n(120);
        // R10: idle stretch with random valid
        drop_mod = 3;
        run_n(50);

        // random phase
        for (int it = 0; it < 60; it++) begin
            if (($urandom % 2) == 0) rand_geom();
            if (($urandom % 3) == 0) wr(4'd8, 24'($urandom));
            if (($urandom % 4) == 0) wr(4'd9, 24'($urandom));
            wr(4'd0, 24'(($urandom % 8) << 1 | (($urandom % 5) != 0)));
            drop_mod = int'($urandom % 12);
            drop_last = (($urandom % 4) == 0);
            run_n(20 + int'($urandom % 200));
        end
        finish_up();
    end

endmodule